// File: doc/BRIEF.md
# External Bus Ownership Handshake

This block is the requesting side of a shared external bus. Several access sources inside the chip raise requests. Each request carries a flag that says whether it targets external space. A software hold bit can also keep the request line up. The block turns these into a single registered bus-request output. It then follows the grant and busy lines of an outside arbiter to decide when it may act as bus master.

The block takes mastership only once grant is present and the previous owner has let go of busy. While it is master it drives its own busy output. It may stay master with no request pending while grant stays present, which is known as parking. When grant goes away, it finishes the memory cycle in progress and then hands the bus back. It keeps busy asserted for one clock after the handover.

The memory cycle timing sits outside this block. That logic reports a running cycle on a cycle-active input. It may start a new cycle only while the start-permit output is high. An access that arrives while the block is not master simply waits for that permit.

Top module: `xbus_owner`

## Requirements
- R1: While reset is applied and right after it, bus request, master, busy and start-permit outputs are all low.
- R2: Bus request is high on the clock after any source is found with both its request and its external flag set, or with the hold bit set. It is low otherwise, whatever the ownership state.
- R3: A source whose external flag is 0 has no effect on bus request, even when its request bit is 1.
- R4: Master rises only on the clock after an edge that found grant high and busy input low in the waiting state. The waiting state is entered from the idle slave state on an edge that sees grant high and bus request high. So mastership comes no sooner than two edges after grant.
- R5: If grant is seen low while waiting for busy, the block returns to slave and does not become master.
- R6: While master, busy output is high. Mastership is kept with bus request low for as long as grant stays high (parking).
- R7: After grant falls, mastership is kept on every edge where cycle-active is high. Master falls on the clock after an edge that sees both grant and cycle-active low.
- R8: Busy output stays high for exactly one clock after master falls, and is low after that.
- R9: Start-permit is high exactly when master is high and the grant input is high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; grant and busy are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req_i | input | NUM_SRC | Access request per source |
| acc_ext_i | input | NUM_SRC | Per source: 1 = access targets external bus, 0 = internal |
| req_hold_i | input | 1 | Software bit that forces bus request high |
| grant_i | input | 1 | Bus grant from the external arbiter |
| busy_i | input | 1 | Bus busy as seen from the bus (previous owner) |
| cyc_active_i | input | 1 | A memory cycle run by this unit is in progress |
| breq_o | output | 1 | Bus request to the arbiter |
| master_o | output | 1 | Unit currently owns the bus |
| busy_o | output | 1 | Busy driven by this unit while it owns or is leaving the bus |
| start_ok_o | output | 1 | A new memory cycle may start now |

## Verification
A long seeded random run is the main test. Grant changes rarely and busy and cycle-active change often, so the run reaches takeover with and without busy stalls, parking, and handovers delayed by long cycles. Directed sequences isolate the cases the random mix hits only rarely. These are a busy line held high for many clocks after grant, which shows that takeover is deferred rather than immediate. They also cover grant withdrawn during the wait, which shows that waiting is abandoned. Another is internal-only requests next to external ones, which separates the external flag from the raw request. The last is grant dropped mid-cycle, which shows that handover happens at the cycle boundary and is followed by the one-clock busy tail.

// File: rtl/xbo_pkg.sv
package xbo_pkg;

    typedef enum logic [1:0] {
        OWN_SLAVE     = 2'd0,
        OWN_WAIT_BUSY = 2'd1,
        OWN_MASTER    = 2'd2,
        OWN_RELEASE   = 2'd3
    } own_state_e;

    typedef struct packed {
        own_state_e st;
    } own_regs_t;

    typedef struct packed {
        logic breq;
    } req_regs_t;

    localparam own_regs_t OWN_RESET = '{st: OWN_SLAVE};
    localparam req_regs_t REQ_RESET = '{breq: 1'b0};

endpackage

// File: rtl/xbo_req_gen.sv
module xbo_req_gen
    import xbo_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] acc_req_i,
    input  logic [NUM_SRC-1:0] acc_ext_i,
    input  logic               req_hold_i,
    output logic               breq_o
);

    localparam int SRC_W = (NUM_SRC > 1) ? NUM_SRC : 1;

    logic [SRC_W-1:0] ext_need;
    req_regs_t        r_d, r_q;

    // Only accesses flagged as external count toward the request
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
        assign ext_need[g] = acc_req_i[g] & acc_ext_i[g];
    end

    always_comb begin
        r_d      = r_q;
        r_d.breq = (|ext_need) | req_hold_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REQ_RESET;
        else        r_q <= r_d;
    end

    assign breq_o = r_q.breq;

endmodule

// File: rtl/xbo_own_fsm.sv
module xbo_own_fsm
    import xbo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic breq_i,
    input  logic grant_i,
    input  logic busy_i,
    input  logic cyc_active_i,
    output logic master_o,
    output logic busy_o,
    output logic start_ok_o
);

    own_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            OWN_SLAVE: begin
                if (grant_i && breq_i) r_d.st = OWN_WAIT_BUSY;
            end
            OWN_WAIT_BUSY: begin
                // takeover deferred until the previous owner frees the bus
                if (!grant_i)     r_d.st = OWN_SLAVE;
                else if (!busy_i) r_d.st = OWN_MASTER;
            end
            OWN_MASTER: begin
                // parking: stay while granted, request or not
                if (!grant_i && !cyc_active_i) r_d.st = OWN_RELEASE;
            end
            OWN_RELEASE: begin
                r_d.st = OWN_SLAVE;
            end
            default: r_d.st = OWN_SLAVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= OWN_RESET;
        else        r_q <= r_d;
    end

    assign master_o   = (r_q.st == OWN_MASTER);
    assign busy_o     = (r_q.st == OWN_MASTER) || (r_q.st == OWN_RELEASE);
    assign start_ok_o = master_o && grant_i;

endmodule

// File: rtl/xbus_owner.sv
module xbus_owner
    import xbo_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] acc_req_i,
    input  logic [NUM_SRC-1:0] acc_ext_i,
    input  logic               req_hold_i,
    input  logic               grant_i,
    input  logic               busy_i,
    input  logic               cyc_active_i,
    output logic               breq_o,
    output logic               master_o,
    output logic               busy_o,
    output logic               start_ok_o
);

    logic breq_w;

    xbo_req_gen #(.NUM_SRC(NUM_SRC)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_req_i  (acc_req_i),
        .acc_ext_i  (acc_ext_i),
        .req_hold_i (req_hold_i),
        .breq_o     (breq_w)
    );

    xbo_own_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .breq_i       (breq_w),
        .grant_i      (grant_i),
        .busy_i       (busy_i),
        .cyc_active_i (cyc_active_i),
        .master_o     (master_o),
        .busy_o       (busy_o),
        .start_ok_o   (start_ok_o)
    );

    assign breq_o = breq_w;

endmodule

// File: rtl/xbus_owner_chk.sv
module xbus_owner_chk #(
    parameter int NUM_SRC = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] acc_req_i,
    input logic [NUM_SRC-1:0] acc_ext_i,
    input logic               req_hold_i,
    input logic               grant_i,
    input logic               busy_i,
    input logic               cyc_active_i,
    input logic               breq_o,
    input logic               master_o,
    input logic               busy_o,
    input logic               start_ok_o
);

    a_r2_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (breq_o == ((|($past(acc_req_i) & $past(acc_ext_i))) || $past(req_hold_i))));

    a_r4_takeover_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master_o) |-> ($past(grant_i) && !$past(busy_i)));

    a_r6_busy_while_master: assert property (@(posedge clk) disable iff (!rst_n)
        master_o |-> busy_o);

    a_r7_hold_until_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (master_o && (grant_i || cyc_active_i)) |=> master_o);

    a_r8_busy_tail: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(master_o) |-> busy_o);

    a_r8_busy_tail_end: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !master_o) |=> !busy_o);

    a_r9_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok_o |-> (busy_o && grant_i));

endmodule

bind xbus_owner xbus_owner_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/xbus_owner_test.sv
module xbus_owner_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] acc_req = '0;
    logic [NSRC-1:0] acc_ext = '0;
    logic            hold = 1'b0, grant = 1'b0, busy_in = 1'b0, cyc = 1'b0;
    logic            breq, master, busy_out, start_ok;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench reference: 0 slave, 1 waiting, 2 master, 3 release
    int   m_st = 0;
    logic m_breq = 1'b0;

    xbus_owner #(.NUM_SRC(NSRC)) uut (
        .clk(clk), .rst_n(rst_n), .acc_req_i(acc_req), .acc_ext_i(acc_ext),
        .req_hold_i(hold), .grant_i(grant), .busy_i(busy_in), .cyc_active_i(cyc),
        .breq_o(breq), .master_o(master), .busy_o(busy_out), .start_ok_o(start_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_breq(logic [NSRC-1:0] rq, logic [NSRC-1:0] ex, logic h);
        return (|(rq & ex)) | h;
    endfunction

    function automatic int next_st(int s, logic br, logic g, logic b, logic c);
        case (s)
            0: return (g && br) ? 1 : 0;
            1: return !g ? 0 : (!b ? 2 : 1);
            2: return (!g && !c) ? 3 : 2;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " R2"}, "breq",     breq,     m_breq);
        chk({tag, " R4"}, "master",   master,   m_st == 2);
        chk({tag, " R6 R8"}, "busy_o", busy_out, (m_st == 2) || (m_st == 3));
        chk({tag, " R9"}, "start_ok", start_ok, (m_st == 2) && grant);
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        m_st   = next_st(m_st, m_breq, grant, busy_in, cyc);
        m_breq = exp_breq(acc_req, acc_ext, hold);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic drive(logic [NSRC-1:0] rq, logic [NSRC-1:0] ex, logic h,
                         logic g, logic b, logic c);
        acc_req = rq; acc_ext = ex; hold = h; grant = g; busy_in = b; cyc = c;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state, with busy-looking inputs present
        drive('1, '1, 1'b1, 1'b1, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R1", "breq", breq, 1'b0);
        chk("R1", "master", master, 1'b0);
        chk("R1", "busy_o", busy_out, 1'b0);
        chk("R1", "start_ok", start_ok, 1'b0);
        drive('0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        step("R1");

        // R3: internal-only requests never raise bus request
        drive(3'b111, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R3"); chk("R3", "breq internal", breq, 1'b0);
        drive(3'b010, 3'b101, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R3"); chk("R3", "breq flag mismatch", breq, 1'b0);
        drive(3'b100, 3'b100, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R2"); chk("R2", "breq external", breq, 1'b1);
        drive(3'b000, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
        step("R2"); chk("R2", "breq hold bit", breq, 1'b1);

        // R4: grant while busy held by previous owner for several clocks
        drive(3'b001, 3'b001, 1'b0, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) begin
            step("R4"); chk("R4", "master deferred", master, 1'b0);
        end
        busy_in = 1'b0;
        step("R4"); chk("R4", "master after busy free", master, 1'b1);
        chk("R9", "start_ok granted master", start_ok, 1'b1);

        // R6: parking, request gone, grant kept
        drive('0, '0, 1'b0, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step("R6"); chk("R6", "parked master", master, 1'b1);
        end
        chk("R6", "parked breq", breq, 1'b0);

        // R7: grant dropped mid-cycle, mastership held to boundary
        drive('0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk); chk("R9", "start_ok after grant loss", start_ok, 1'b0);
        for (int i = 0; i < 3; i++) begin
            step("R7"); chk("R7", "master during cycle", master, 1'b1);
        end
        cyc = 1'b0;
        step("R7"); chk("R7", "master after boundary", master, 1'b0);
        chk("R8", "busy tail", busy_out, 1'b1);
        step("R8"); chk("R8", "busy tail end", busy_out, 1'b0);

        // R5: grant withdrawn while waiting for busy
        drive(3'b010, 3'b010, 1'b0, 1'b1, 1'b1, 1'b0);
        step("R5"); step("R5");
        grant = 1'b0;
        step("R5");
        busy_in = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step("R5"); chk("R5", "no master after abandon", master, 1'b0);
        end

        // random phase
        void'($urandom(32'h5eed_0c1a));
        for (int i = 0; i < 4000; i++) begin
            acc_req = NSRC'($urandom);
            acc_ext = NSRC'($urandom);
            hold    = ($urandom_range(7) == 0);
            if ($urandom_range(9) == 0) grant = ~grant;
            busy_in = ($urandom_range(2) == 0);
            cyc     = ($urandom_range(3) != 0);
            step("RND");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule